// File: doc/BRIEF.md
# Synchronous rectifier gate sequencer

This block decides, one clock at a time, whether the gate of a synchronous-rectifier switch should be driven. It sees the sense node only through digitized comparator events: a turn-on event (sense has dropped below the turn-on threshold), a zero-current event (sense has climbed back to zero), and a reset-level event (sense is well above the rearm level). A trigger qualifier can also request an immediate turn-off. An enable input represents undervoltage or disable mode.

Blanking guards the gate against ringing. Each conduction pulse has a minimum length, chosen by a 4-bit preset code. Each off interval also has a minimum length, chosen by a second 4-bit code. A watchdog ends any pulse that runs too long. Every duration is given in nanoseconds and converted to clock counts from a clock-period parameter, rounding up. A new pulse is accepted only once the sequencer has been rearmed. Rearming happens when a reset-level event is seen while the gate is off. It can also happen through an optional exception timer: after the off blank ends, this timer counts four minimum on-times and then rearms the sequencer without a reset-level event. Each finished pulse produces a one-cycle completion strobe for a light-load detector. A second one-cycle strobe flags pulses that the watchdog ended.

Top module: `srg_gate_seq`

## Requirements
- R1: While reset is asserted, the gate, the completion strobe and the watchdog strobe are all low, and the sequencer is not armed.
- R2: When the sequencer is idle, armed and enabled, a turn-on event sampled at a clock edge raises the gate right after that edge. A reset-level event in the same cycle counts as armed.
- R3: Once the gate rises, zero-current and fast-off requests are ignored until the gate has been high for N cycles. N = ceil(t/clock period), where t is the minimum on-time preset. Codes 0 to 12 select, in ascending order, 130, 220, 310, 400, 500, 600, 700, 800, 1000, 1200, 1400, 1700 and 2000 ns. Codes 13 to 15 also select 2000 ns. If a turn-off request is held throughout, the pulse lasts exactly N cycles.
- R4: After the minimum on-time, a zero-current event sampled at an edge lowers the gate right after that edge.
- R5: A fast-off request obeys the same blanking as a zero-current event and turns the gate off at the same edge. A request that comes and goes entirely inside the blank has no effect.
- R6: After the gate falls, it stays low for at least K cycles, and turn-on events during that time are ignored. K = ceil(t/clock period), where t is the minimum off-time preset. Codes 0 to 14 select, in ascending order, 0.9, 1.0, 1.1, 1.2, 1.4, 1.6, 1.8, 2.0, 2.2, 2.4, 2.6, 2.9, 3.2, 3.5 and 3.9 µs. Code 15 also selects 3.9 µs. If the sequencer is armed and a turn-on event is held, the gate rises again exactly K cycles after it fell.
- R7: A reset-level event seen while the gate is off arms the sequencer. The arm is kept until the next turn-on. A turn-on event without an arm does not raise the gate.
- R8: When the exception timer is present and nothing has armed the sequencer, it arms itself 4·N cycles after the off blank ends. With a turn-on event held, the gate is then low for exactly K + 4·N cycles.
- R9: A pulse that reaches M cycles is ended by the watchdog, where M = ceil(maximum pulse length/clock period). This happens even if no turn-off request arrives. The watchdog strobe is high for exactly the first cycle the gate is low.
- R10: The completion strobe is high for exactly the first cycle after each turn-off that happens while enabled, and at no other time.
- R11: While enable is low, the gate is forced low at the next edge without a completion strobe, and all timers and the arm are cleared. After enable returns, the sequencer behaves as if it had been idle for zero cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Low = undervoltage or disable mode |
| senseOnEvt | input | 1 | Sense is below the turn-on threshold |
| senseZeroEvt | input | 1 | Sense has reached the zero-current threshold |
| senseResetEvt | input | 1 | Sense is above the rearm level |
| fastOffReq | input | 1 | Qualified fast turn-off request from the trigger path |
| onTimeSel | input | 4 | Minimum on-time preset code |
| offTimeSel | input | 4 | Minimum off-time preset code |
| gateDrv | output | 1 | Gate-drive command |
| cycleDone | output | 1 | One-cycle strobe after each completed pulse |
| wdTrip | output | 1 | One-cycle strobe when the watchdog ended a pulse |

## Verification
The hardest case to reach is a turn-on held off by a missing arm. The sequencer must sit through the whole off blank and then the exception count. Only then may it rearm, so the low interval grows from K to K + 4·N cycles. The stimulus produces this state by pulsing the reset-level event only for the first turn-on and then holding the turn-on event through the next off interval. The bench checks the low interval against K + 4·N for several preset pairs. A companion case pulses the reset-level event once, early in the off blank, so that the gate rises at K and not later.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_ON      = 2'd1,
    ST_HOLDOFF = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
  } ctrlStrobe_t;

  // threshold flags from datapath to control
  typedef struct packed {
    logic onDone;
    logic wdDone;
    logic offDone;
    logic excDone;
  } timerFlags_t;

  localparam int NUM_SEL = 16;

  function automatic longint unsigned onPresetNs(input logic [3:0] sel);
    case (sel)
      4'd0:    return 130;
      4'd1:    return 220;
      4'd2:    return 310;
      4'd3:    return 400;
      4'd4:    return 500;
      4'd5:    return 600;
      4'd6:    return 700;
      4'd7:    return 800;
      4'd8:    return 1000;
      4'd9:    return 1200;
      4'd10:   return 1400;
      4'd11:   return 1700;
      default: return 2000;
    endcase
  endfunction

  function automatic longint unsigned offPresetNs(input logic [3:0] sel);
    case (sel)
      4'd0:    return 900;
      4'd1:    return 1000;
      4'd2:    return 1100;
      4'd3:    return 1200;
      4'd4:    return 1400;
      4'd5:    return 1600;
      4'd6:    return 1800;
      4'd7:    return 2000;
      4'd8:    return 2200;
      4'd9:    return 2400;
      4'd10:   return 2600;
      4'd11:   return 2900;
      4'd12:   return 3200;
      4'd13:   return 3500;
      default: return 3900;
    endcase
  endfunction

  // round-up conversion of nanoseconds to clock cycles
  function automatic longint unsigned nsToCycles(input longint unsigned ns,
                                                  input longint unsigned periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/srg_timers.sv
module srg_timers
  import srg_pkg::*;
#(
  parameter int unsigned     CLK_PERIOD_PS = 20000,
  parameter longint unsigned MAX_ON_NS     = 4000000,
  parameter bit              EXC_EN        = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [3:0]  onSel,
  input  logic [3:0]  offSel,
  output timerFlags_t flags
);

  localparam longint unsigned WD_CYC      = nsToCycles(MAX_ON_NS, CLK_PERIOD_PS);
  localparam longint unsigned ON_TOP_CYC  = nsToCycles(onPresetNs(4'd15), CLK_PERIOD_PS);
  localparam longint unsigned OFF_TOP_CYC = nsToCycles(offPresetNs(4'd15), CLK_PERIOD_PS);
  localparam longint unsigned EXC_TOP_CYC = 4 * ON_TOP_CYC;
  localparam longint unsigned MAX_A       = (WD_CYC > EXC_TOP_CYC) ? WD_CYC : EXC_TOP_CYC;
  localparam longint unsigned CNT_MAX     = (MAX_A > OFF_TOP_CYC) ? MAX_A : OFF_TOP_CYC;
  localparam int              CNT_W       = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] WD_LIM     = CNT_W'(WD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] onLimTab  [NUM_SEL];
  logic [CNT_W-1:0] offLimTab [NUM_SEL];
  logic             excHit;

  // per-preset compare limits, stored as count minus one
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign onLimTab[g]  = CNT_W'(nsToCycles(onPresetNs(4'(g)), CLK_PERIOD_PS) - 1);
    assign offLimTab[g] = CNT_W'(nsToCycles(offPresetNs(4'(g)), CLK_PERIOD_PS) - 1);
  end

  if (EXC_EN) begin : g_exc
    logic [CNT_W-1:0] excLimTab [NUM_SEL];
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_excLim
      assign excLimTab[g] = CNT_W'(4 * nsToCycles(onPresetNs(4'(g)), CLK_PERIOD_PS) - 1);
    end
    assign excHit = (cnt >= excLimTab[onSel]);
  end else begin : g_noExc
    assign excHit = 1'b0;
  end

  // single phase counter, cleared by control on every phase change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clrCnt) begin
      cnt <= '0;
    end else if (cnt != CNT_SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    flags.onDone  = (cnt >= onLimTab[onSel]);
    flags.offDone = (cnt >= offLimTab[offSel]);
    flags.wdDone  = (cnt >= WD_LIM);
    flags.excDone = excHit;
  end

  // R11: a clear strobe always leaves the counter at zero
  p_cnt_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (cnt == '0));

  // counter never moves past its saturation value
  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_SAT) |=> (cnt == CNT_SAT) || (cnt == '0));

endmodule

// File: rtl/srg_control.sv
module srg_control
  import srg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        csOn,
  input  logic        csZero,
  input  logic        csReset,
  input  logic        fastOff,
  input  timerFlags_t flags,
  output ctrlStrobe_t strobe,
  output logic        gateDrv,
  output logic        cycleDone,
  output logic        wdTrip
);

  seqState_t state, stateNext;
  logic      armed;
  logic      armNow;
  logic      turnOn;
  logic      turnOff;
  logic      wdForce;

  always_comb begin
    armNow    = armed || csReset || ((state == ST_READY) && flags.excDone);
    wdForce   = (state == ST_ON) && flags.wdDone;
    turnOff   = (state == ST_ON) && (wdForce || (flags.onDone && (csZero || fastOff)));
    turnOn    = 1'b0;
    stateNext = state;
    case (state)
      ST_READY: begin
        if (csOn && armNow) begin
          turnOn    = 1'b1;
          stateNext = ST_ON;
        end
      end
      ST_ON: begin
        if (turnOff) stateNext = ST_HOLDOFF;
      end
      ST_HOLDOFF: begin
        if (flags.offDone) begin
          if (csOn && armNow) begin
            turnOn    = 1'b1;
            stateNext = ST_ON;
          end else begin
            stateNext = ST_READY;
          end
        end
      end
      default: stateNext = ST_READY;
    endcase
    if (!enable) begin
      turnOn    = 1'b0;
      stateNext = ST_READY;
    end
    strobe.clrCnt = (stateNext != state) || !enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READY;
      armed     <= 1'b0;
      cycleDone <= 1'b0;
      wdTrip    <= 1'b0;
    end else begin
      state     <= stateNext;
      cycleDone <= turnOff && enable;
      wdTrip    <= wdForce && enable;
      if (!enable || turnOn) begin
        armed <= 1'b0;
      end else if (csReset && (state != ST_ON)) begin
        armed <= 1'b1;
      end
    end
  end

  assign gateDrv = (state == ST_ON);

  // R11: disable forces the gate low on the next edge
  p_gate_low_disabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateDrv);

  // R3: a pulse ends only once the on blank or the watchdog limit is reached
  p_min_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateDrv) && $past(enable)) |-> $past(flags.onDone || flags.wdDone));

  // R6: a pulse that follows an off blank starts only after the blank is over
  p_min_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateDrv) && ($past(state) == ST_HOLDOFF)) |-> $past(flags.offDone));

  // R10: completion strobe marks the first low cycle after a pulse
  p_cycle_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (!gateDrv && $past(gateDrv)));

  // R9: the watchdog strobe always accompanies a completion strobe
  p_wd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdTrip |-> cycleDone);

endmodule

// File: rtl/srg_gate_seq.sv
module srg_gate_seq
  import srg_pkg::*;
#(
  parameter int unsigned     CLK_PERIOD_PS = 20000,
  parameter longint unsigned MAX_ON_NS     = 4000000,
  parameter bit              EXC_EN        = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       senseOnEvt,
  input  logic       senseZeroEvt,
  input  logic       senseResetEvt,
  input  logic       fastOffReq,
  input  logic [3:0] onTimeSel,
  input  logic [3:0] offTimeSel,
  output logic       gateDrv,
  output logic       cycleDone,
  output logic       wdTrip
);

  ctrlStrobe_t strobe;
  timerFlags_t flags;

  srg_timers #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MAX_ON_NS     (MAX_ON_NS),
    .EXC_EN        (EXC_EN)
  ) u_timers (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .onSel  (onTimeSel),
    .offSel (offTimeSel),
    .flags  (flags)
  );

  srg_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .csOn      (senseOnEvt),
    .csZero    (senseZeroEvt),
    .csReset   (senseResetEvt),
    .fastOff   (fastOffReq),
    .flags     (flags),
    .strobe    (strobe),
    .gateDrv   (gateDrv),
    .cycleDone (cycleDone),
    .wdTrip    (wdTrip)
  );

endmodule

// File: tb/srg_gate_seq_tb.sv
`timescale 1ns/1ps
module srg_gate_seq_tb;

  localparam int WD_CYC = 300; // 6000 ns at 20 ns

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       csOn = 1'b0, csOff = 1'b0, csReset = 1'b0, fastOff = 1'b0;
  logic [3:0] onSel = 4'd0, offSel = 4'd0;
  logic       gateDrv, cycleDone, wdTrip;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  srg_gate_seq #(
    .CLK_PERIOD_PS (20000),
    .MAX_ON_NS     (6000),
    .EXC_EN        (1'b1)
  ) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .senseOnEvt    (csOn),
    .senseZeroEvt  (csOff),
    .senseResetEvt (csReset),
    .fastOffReq    (fastOff),
    .onTimeSel     (onSel),
    .offTimeSel    (offSel),
    .gateDrv       (gateDrv),
    .cycleDone     (cycleDone),
    .wdTrip        (wdTrip)
  );

  function automatic int expOn(input int sel);
    int ns [13] = '{130, 220, 310, 400, 500, 600, 700, 800, 1000, 1200, 1400, 1700, 2000};
    int t = (sel > 12) ? 2000 : ns[sel];
    return (t + 19) / 20;
  endfunction

  function automatic int expOff(input int sel);
    int ns [15] = '{900, 1000, 1100, 1200, 1400, 1600, 1800, 2000, 2200, 2400,
                    2600, 2900, 3200, 3500, 3900};
    int t = (sel > 14) ? 3900 : ns[sel];
    return (t + 19) / 20;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedge samples while the gate equals lvl
  task automatic runLen(input logic lvl, output int n);
    n = 0;
    while (gateDrv === lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    csOn = 1'b0; csReset = 1'b0; fastOff = 1'b0; csOff = 1'b1;
    for (int i = 0; i < 500 && gateDrv !== 1'b0; i++) @(negedge clk);
    csOff = 1'b0;
    repeat (250) @(negedge clk);
  endtask

  // arm and start one pulse; returns at the first high sample
  task automatic armOn();
    csOn = 1'b1; csReset = 1'b1;
    @(negedge clk);
    csOn = 1'b0; csReset = 1'b0;
  endtask

  task automatic osc(input int onS, input int offS, input bit useFast);
    int h, l;
    onSel = 4'(onS); offSel = 4'(offS);
    settle();
    csOn = 1'b1; csReset = 1'b1;
    if (useFast) fastOff = 1'b1; else csOff = 1'b1;
    @(negedge clk);
    check(gateDrv === 1'b1, "R2 turn-on", int'(gateDrv), 1);
    runLen(1'b1, h);
    check(h == expOn(onS), useFast ? "R5 fast-off width" : "R3 min-on width", h, expOn(onS));
    check(cycleDone === 1'b1 && wdTrip === 1'b0, "R10 completion strobe",
          int'({cycleDone, wdTrip}), 2);
    runLen(1'b0, l);
    check(l == expOff(offS), "R6 min-off width", l, expOff(offS));
    settle();
  endtask

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    check(gateDrv === 1'b0 && cycleDone === 1'b0 && wdTrip === 1'b0, "R1 reset state",
          int'({gateDrv, cycleDone, wdTrip}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: turn-on event without arm (exception needs 400 cycles here)
    onSel = 4'd12;
    csOn = 1'b1;
    repeat (100) @(negedge clk);
    check(gateDrv === 1'b0, "R7 unarmed turn-on ignored", int'(gateDrv), 0);
    csOn = 1'b0;
    settle();

    // R3/R6 sweeps over every preset code
    for (int s = 0; s < 16; s++) osc(s, 0, 1'b0);
    for (int s = 0; s < 16; s++) osc(0, s, 1'b0);
    osc(3, 7, 1'b1);

    // R4: late zero-current event
    onSel = 4'd2; offSel = 4'd0;
    armOn();
    repeat (40) @(negedge clk);
    check(gateDrv === 1'b1, "R4 held without request", int'(gateDrv), 1);
    csOff = 1'b1;
    @(negedge clk);
    check(gateDrv === 1'b0, "R4 zero-current turn-off", int'(gateDrv), 0);
    settle();

    // R5: fast-off pulse inside blank is ignored
    onSel = 4'd5;
    armOn();
    repeat (3) @(negedge clk);
    fastOff = 1'b1;
    repeat (5) @(negedge clk);
    fastOff = 1'b0;
    repeat (32) @(negedge clk);
    check(gateDrv === 1'b1, "R5 fast-off in blank ignored", int'(gateDrv), 1);
    fastOff = 1'b1;
    @(negedge clk);
    check(gateDrv === 1'b0, "R5 fast-off after blank", int'(gateDrv), 0);
    settle();

    // R7: arm taken early in off blank is kept
    onSel = 4'd0; offSel = 4'd4;
    armOn();
    csOn = 1'b1; csOff = 1'b1;
    runLen(1'b1, h);
    csOff = 1'b0; csReset = 1'b1;
    @(negedge clk);
    csReset = 1'b0;
    runLen(1'b0, l);
    check(l == expOff(4) - 1, "R7 arm kept through blank", l, expOff(4) - 1);
    settle();

    // R8: exception rearm for several preset pairs
    for (int k = 0; k < 3; k++) begin
      int on_s  = (k == 0) ? 0 : (k == 1) ? 12 : 4;
      int off_s = (k == 2) ? 14 : 0;
      onSel = 4'(on_s); offSel = 4'(off_s);
      armOn();
      csOn = 1'b1; csOff = 1'b1;
      runLen(1'b1, h);
      runLen(1'b0, l);
      check(l == expOff(off_s) + 4 * expOn(on_s), "R8 exception rearm", l,
            expOff(off_s) + 4 * expOn(on_s));
      check(l > expOff(off_s), "R7 no turn-on without arm", l, expOff(off_s) + 1);
      settle();
    end

    // R9: watchdog
    onSel = 4'd0; offSel = 4'd0;
    armOn();
    runLen(1'b1, h);
    check(h == WD_CYC, "R9 watchdog width", h, WD_CYC);
    check(wdTrip === 1'b1 && cycleDone === 1'b1, "R9 watchdog strobe",
          int'({wdTrip, cycleDone}), 3);
    @(negedge clk);
    check(wdTrip === 1'b0 && cycleDone === 1'b0, "R10 strobe one cycle",
          int'({wdTrip, cycleDone}), 0);
    settle();

    // R11: disable mid-pulse
    armOn();
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(gateDrv === 1'b0 && cycleDone === 1'b0, "R11 disable forces off",
          int'({gateDrv, cycleDone}), 0);
    csOn = 1'b1; csReset = 1'b1;
    repeat (5) @(negedge clk);
    check(gateDrv === 1'b0, "R11 held off while disabled", int'(gateDrv), 0);
    csReset = 1'b0; onSel = 4'd2; enable = 1'b1;
    runLen(1'b0, l);
    check(l == 4 * expOn(2), "R11 fresh start after enable", l, 4 * expOn(2));
    settle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule